// File: doc/BRIEF.md
# Fan Speed Controller

This block drives a single cooling fan and measures how fast it turns. A duty register sets the on-time of a fixed-period PWM output. A tachometer input is synchronized and its rising edges are counted over a fixed gate window. At the end of each window the count is turned into revolutions per minute, and software reads that value directly from a second register. It does not have to scale a raw pulse count.

Software reaches the block over a plain synchronous register bus. A cycle with `bus_ce` high and `bus_we` high is a write. A cycle with `bus_ce` high and `bus_we` low is a read, and its data appears on `bus_rdata` one clock later. The bus has no back-pressure: every access with `bus_ce` high completes in the cycle it is presented. The PWM output and the tach input are plain pins.

Top module: `fan_speed_ctrl`

## Requirements
- R1: A write (`bus_ce`=1, `bus_we`=1) to address 0 stores `bus_wdata[7:0]` as the duty. Bits 15:8 of the write data are ignored.
- R2: A read (`bus_ce`=1, `bus_we`=0) updates `bus_rdata` on the next clock edge. Address 0 returns {8'h00, duty} and address 1 returns the speed. When there is no read, `bus_rdata` holds its value.
- R3: The PWM phase advances once every PRESCALE clocks and runs through 255 steps, 0 to 254. `pwm_out` is high while the phase is below the duty. A duty of 0x00 keeps the output low for the whole period, and 0xFF keeps it high for the whole period.
- R4: `tach_in` goes through a two-flop synchronizer. Each 0-to-1 transition is counted exactly once, including pulses only one clock wide, two clocks after the input is sampled.
- R5: The gate window is GATE_CYCLES clocks long. At the end of each window the speed register is loaded with floor(pulses × 60 / PULSES_PER_REV), and the pulse count restarts from zero.
- R6: A computed speed above 0xFFFF saturates to 0xFFFF.
- R7: The speed reads 0 until the first window completes. It changes only at a window end, so every read returns the result of one whole window.
- R8: Writes to address 1 change nothing. Cycles with `bus_ce` low perform no access, even with `bus_we` high.
- R9: While `rst_n` is low, the duty, the speed, `bus_rdata` and `pwm_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Access enable for the register bus |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Register address: 0 = duty, 1 = speed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one clock after a read |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| pwm_out | output | 1 | PWM drive to the fan |

## Verification
The speed register is hard to exercise fully from the ports, because it changes only at window boundaries. The saturation path also needs more pulses in a window than a real fan would produce. The bench shortens the gate window and uses an odd pulses-per-revolution value, so truncation is visible. It then runs whole windows with several tach patterns: a toggle on every clock that forces saturation, slower square waves, a stuck-low input and pseudo-random single-clock pulses. Speed reads are spread across every window, including the first one, where the value must still be zero.

// File: rtl/fan_ctrl_pkg.sv
`timescale 1ns/1ps
package fan_ctrl_pkg;
  localparam int REG_W      = 16;
  localparam int DUTY_W     = 8;
  localparam int PWM_STEPS  = 255;
  localparam int SEC_PER_MIN = 60;
  localparam logic [REG_W-1:0] SPEED_MAX = 16'hFFFF;

  typedef enum logic {
    SEL_DUTY  = 1'b0,
    SEL_SPEED = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/fan_pwm_gen.sv
`timescale 1ns/1ps
module fan_pwm_gen
  import fan_ctrl_pkg::*;
#(
  parameter int PRESCALE = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_out
);
  localparam logic [DUTY_W-1:0] PHASE_LAST = DUTY_W'(PWM_STEPS - 1);

  logic              step;
  logic [DUTY_W-1:0] phase;

  generate
    if (PRESCALE <= 1) begin : g_no_div
      assign step = 1'b1;
    end else begin : g_div
      localparam int PS_W = $clog2(PRESCALE);
      logic [PS_W-1:0] ps_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               ps_cnt <= '0;
        else if (ps_cnt == PS_W'(PRESCALE - 1))   ps_cnt <= '0;
        else                                      ps_cnt <= ps_cnt + 1'b1;
      end
      assign step = (ps_cnt == PS_W'(PRESCALE - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (step) begin
      if (phase == PHASE_LAST)  phase <= '0;
      else                      phase <= phase + 1'b1;
    end
  end

  assign pwm_out = (phase < duty);

  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 8'hFF);
  a_r3_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == 8'h00) |-> !pwm_out);
  a_r3_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == 8'hFF) |-> pwm_out);
endmodule

// File: rtl/fan_tach_sync.sv
`timescale 1ns/1ps
module fan_tach_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  output logic tach_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= tach_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign tach_rise = sync_q & ~prev_q;

  a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    tach_rise |=> !tach_rise);
endmodule

// File: rtl/fan_rpm_meter.sv
`timescale 1ns/1ps
module fan_rpm_meter
  import fan_ctrl_pkg::*;
#(
  parameter int GATE_CYCLES    = 200_000_000,
  parameter int PULSES_PER_REV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_rise,
  output logic [REG_W-1:0] rpm
);
  localparam int GATE_W = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam int CNT_W  = $clog2(GATE_CYCLES + 1);
  localparam int PROD_W = (CNT_W + 6 > REG_W + 1) ? CNT_W + 6 : REG_W + 1;

  logic [GATE_W-1:0] gate_cnt;
  logic              gate_end;
  logic [CNT_W-1:0]  pulse_cnt;
  logic [CNT_W-1:0]  total;
  logic [PROD_W-1:0] prod, quot;
  logic [REG_W-1:0]  rpm_next;

  assign gate_end = (gate_cnt == GATE_W'(GATE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        gate_cnt <= '0;
    else if (gate_end) gate_cnt <= '0;
    else               gate_cnt <= gate_cnt + 1'b1;
  end

  assign total = pulse_cnt + CNT_W'(tach_rise);
  assign prod  = PROD_W'(total) * PROD_W'(SEC_PER_MIN);
  assign quot  = prod / PROD_W'(PULSES_PER_REV);
  assign rpm_next = (quot > PROD_W'(SPEED_MAX)) ? SPEED_MAX : quot[REG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
      rpm       <= '0;
    end else if (gate_end) begin
      pulse_cnt <= '0;
      rpm       <= rpm_next;
    end else begin
      pulse_cnt <= total;
    end
  end

  a_r7_hold_between_windows: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_end |=> $stable(rpm));
  a_r5_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> (pulse_cnt == '0));
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_end && quot > PROD_W'(SPEED_MAX)) |=> (rpm == SPEED_MAX));
endmodule

// File: rtl/fan_speed_ctrl.sv
`timescale 1ns/1ps
module fan_speed_ctrl
  import fan_ctrl_pkg::*;
#(
  parameter int GATE_CYCLES    = 200_000_000,
  parameter int PULSES_PER_REV = 2,
  parameter int PRESCALE       = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_ce,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        tach_in,
  output logic        pwm_out
);
  logic [DUTY_W-1:0] duty_q;
  logic [REG_W-1:0]  speed;
  logic              tach_rise;
  logic              wr_duty, rd_any;
  reg_sel_e          sel;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_duty = bus_ce && bus_we && (sel == SEL_DUTY);
  assign rd_any  = bus_ce && !bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (wr_duty) duty_q <= bus_wdata[DUTY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_any) begin
      if (sel == SEL_DUTY) bus_rdata <= {{(REG_W-DUTY_W){1'b0}}, duty_q};
      else                 bus_rdata <= speed;
    end
  end

  fan_pwm_gen #(.PRESCALE(PRESCALE)) u_pwm (
    .clk(clk), .rst_n(rst_n), .duty(duty_q), .pwm_out(pwm_out)
  );

  fan_tach_sync u_sync (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .tach_rise(tach_rise)
  );

  fan_rpm_meter #(.GATE_CYCLES(GATE_CYCLES), .PULSES_PER_REV(PULSES_PER_REV)) u_meter (
    .clk(clk), .rst_n(rst_n), .tach_rise(tach_rise), .rpm(speed)
  );

  a_r1_duty_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && bus_we && !bus_addr) |=> (duty_q == $past(bus_wdata[7:0])));
  a_r8_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ce && bus_we && !bus_addr) |=> $stable(duty_q));
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ce && !bus_we) |=> $stable(bus_rdata));
  a_r2_duty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ce && !bus_we && !bus_addr) |=> (bus_rdata[15:8] == 8'h00));
endmodule

// File: tb/fan_speed_ctrl_tb.sv
`timescale 1ns/1ps
module fan_speed_ctrl_tb;
  localparam int GATE = 16000;
  localparam int PPR  = 7;
  localparam int PRE  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_ce = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tach_in = 1'b0;
  logic        pwm_out;

  always #2.5 clk = ~clk;

  fan_speed_ctrl #(.GATE_CYCLES(GATE), .PULSES_PER_REV(PPR), .PRESCALE(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tach_in(tach_in), .pwm_out(pwm_out)
  );

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference model state
  int   edge_n = 0, m_cnt = 0, m_windows = 0;
  int   m_duty = 0, m_rpm = 0, m_rdata = 0;
  bit   th[$] = '{0, 0, 0};
  string last_tag = "R2";

  // tach stimulus state
  int        tmode = 1, thalf = 1, tcnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, edge_n);
    end
  endtask

  task automatic model_and_compare();
    bit rise;
    int q, phase;
    edge_n++;
    // R2: read data captured from pre-edge state
    if (bus_ce && !bus_we) begin
      if (!bus_addr) begin m_rdata = m_duty; last_tag = "R1"; end
      else begin
        m_rdata = m_rpm;
        if (m_windows == 0)      last_tag = "R7";
        else if (m_rpm == 65535) last_tag = "R6";
        else                     last_tag = (tmode == 2) ? "R4" : "R5";
      end
    end else last_tag = "R2";
    // R1, R8: only ce&we to address 0 alters duty
    if (bus_ce && bus_we && !bus_addr) m_duty = int'(bus_wdata[7:0]);
    // R4: input seen at the edge n is counted at edge n+2
    th.push_front(tach_in);
    rise = th[2] && !th[3];
    void'(th.pop_back());
    if (rise) m_cnt++;
    // R5, R6
    if (edge_n % GATE == 0) begin
      q = m_cnt * 60 / PPR;
      m_rpm = (q > 65535) ? 65535 : q;
      m_cnt = 0;
      m_windows++;
    end
    // R3
    phase = (edge_n / PRE) % 255;
    check(pwm_out === (phase < m_duty), "R3", int'(pwm_out), int'(phase < m_duty));
    check(bus_rdata === 16'(m_rdata), last_tag, int'(bus_rdata), m_rdata);
  endtask

  task automatic step();
    @(negedge clk);
    model_and_compare();
    tcnt++;
    case (tmode)
      0: tach_in = 1'b0;
      1: if (tcnt >= thalf) begin tcnt = 0; tach_in = ~tach_in; end
      default: tach_in = lfsr[3] & lfsr[9];
    endcase
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic bus(input bit ce, input bit we, input bit a, input logic [15:0] d);
    bus_ce = ce; bus_we = we; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic rnd_op();
    case (lfsr[2:0])
      3'd0:       bus(1, 1, 0, {lfsr[7:0], lfsr[15:8]});   // R1
      3'd1:       bus(1, 1, 1, lfsr);                       // R8 write to speed address
      3'd2, 3'd3: bus(1, 0, 0, lfsr);
      3'd4, 3'd5: bus(1, 0, 1, lfsr);
      3'd6:       bus(0, 1, 0, lfsr);                       // R8 ce low
      default:    bus(0, 0, 0, 16'h0);
    endcase
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9: reset state
    check(bus_rdata === 16'h0, "R9", int'(bus_rdata), 0);
    check(pwm_out === 1'b0, "R9", int'(pwm_out), 0);
    rst_n = 1'b1;
    tmode = 1; thalf = 1;
    bus(1, 1, 0, 16'hAB00);                  // R3 duty 0x00
    repeat (800) bus(1, 0, 1, 16'h0);        // R7 reads 0 in first window
    bus(1, 1, 0, 16'h00FF);                  // R3 duty 0xFF
    repeat (800) bus(1, 0, 0, 16'h0);
    bus(1, 1, 0, 16'h5A12);                  // R1 reserved bits dropped
    bus(1, 0, 0, 16'h0);
    bus(1, 1, 1, 16'h1234);                  // R8
    repeat (20) bus(0, 0, 0, 16'h0);         // R2 hold
    while (edge_n < GATE + 40) rnd_op();     // R6 saturation window
    thalf = 4;
    while (edge_n < 2 * GATE + 40) rnd_op();
    thalf = 23;
    while (edge_n < 3 * GATE + 40) rnd_op();
    tmode = 0;
    while (edge_n < 4 * GATE + 40) rnd_op();
    tmode = 2;                               // R4 single-clock pulses
    while (edge_n < 5 * GATE + 40) rnd_op();
    repeat (50) bus(1, 0, 1, 16'h0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule